// File: doc/BRIEF.md
# GPIO Edge Interrupt Event Unit

This unit watches a bank of general-purpose input lines that come from outside the clock domain. Each line passes through a two-stage synchronizer. The unit then compares the synchronized value with its value one cycle earlier to find rising and falling transitions. When a transition of the kind selected for that line is seen, a sticky event bit is set. Software clears an event bit by writing a one to it. A per-line enable mask gates the event bits into one combined interrupt output.

How each line's sensitivity is configured depends on the elaboration parameter `TWO_BIT_CFG`:

- **Narrow layout (`TWO_BIT_CFG = 0`):** one configuration bit per line. The bit selects either falling-only or both-edges detection.
- **Wide layout (`TWO_BIT_CFG = 1`):** a two-bit code per line, spread over two configuration registers. The code selects rising, falling, both or no edges.

All registers sit on a simple word-aligned register bus. Writes are synchronous and reads are combinational.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset the event, mask and both configuration registers read 0 and `irqOut` is low.
- R2: The byte addresses decode as follows. `0x0C` is the event register, `0x10` is the mask, `0x14` is the first configuration register, and `0x18` is the second configuration register. The second configuration register exists only in the wide layout; in the narrow layout `0x18` reads 0 and writes to it are ignored. Every other address reads 0.
- R3: Line n corresponds to bit (31 − n) of the event and mask registers.
- R4: Writing 1 to an event bit clears it. Writing 0 to an event bit leaves it unchanged.
- R5: `irqOut` is high exactly when some bit is set in both the event and the mask registers. Event bits still set while the line is masked.
- R6: Narrow layout: configuration bit (31 − n) at `0x14` set to 1 detects only falling edges on line n; set to 0 it detects both edges.
- R7: Wide layout field placement: lines 0..15 use `0x14` and lines 16..31 use `0x18`. The field for line n starts at bit (15 − (n mod 16)) × 2.
- R8: Wide layout codes: 2 = falling only, 1 = rising only, 0 = both edges, 3 = no edges.
- R9: If a qualifying edge and a write-1 clear reach the same event bit in the same cycle, the bit stays set.
- R10: A change on `pinIn` that is stable before rising edge k sets the event bit, and `irqOut` if the line is unmasked, after rising edge k+2. Before that edge the event bit is still clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 32 | Asynchronous GPIO inputs, index = line number |
| regAddr | input | 5 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the clock edge that samples them. Reads and `irqOut` follow register state combinationally, so the bench reads each result half a cycle after the write's edge. A pin change is driven on a falling clock edge and reaches the event register on the third rising edge after that. The bench waits four cycles before reading an event and, for the latency requirement, samples on both sides of that third edge. The same-cycle clear-versus-edge case is timed so that the clear strobe sits on exactly that third edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam logic [7:0] OFF_EVT   = 8'h0C;
  localparam logic [7:0] OFF_MASK  = 8'h10;
  localparam logic [7:0] OFF_CFGLO = 8'h14;
  localparam logic [7:0] OFF_CFGHI = 8'h18;

  typedef struct packed {
    logic evClr;
    logic maskWr;
    logic cfgLoWr;
    logic cfgHiWr;
  } regStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_EVT, RD_MASK, RD_CFGLO, RD_CFGHI
  } rdSel_e;
endpackage

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter bit TWO_BIT_CFG = 1'b0
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strb,
  output rdSel_e            rdSel
);
  logic hitEvt, hitMask, hitLo, hitHi;

  assign hitEvt  = (regAddr == ADDR_W'(OFF_EVT));
  assign hitMask = (regAddr == ADDR_W'(OFF_MASK));
  assign hitLo   = (regAddr == ADDR_W'(OFF_CFGLO));
  assign hitHi   = TWO_BIT_CFG && (regAddr == ADDR_W'(OFF_CFGHI));

  always_comb begin
    strb.evClr   = regWrEn && hitEvt;
    strb.maskWr  = regWrEn && hitMask;
    strb.cfgLoWr = regWrEn && hitLo;
    strb.cfgHiWr = regWrEn && hitHi;
    if (hitEvt)       rdSel = RD_EVT;
    else if (hitMask) rdSel = RD_MASK;
    else if (hitLo)   rdSel = RD_CFGLO;
    else if (hitHi)   rdSel = RD_CFGHI;
    else              rdSel = RD_NONE;
  end
endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int LINES       = 32,
  parameter bit TWO_BIT_CFG = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pinIn,
  input  regStrobe_t       strb,
  input  rdSel_e           rdSel,
  input  logic [LINES-1:0] wrData,
  output logic [LINES-1:0] rdData,
  output logic             irqOut
);
  localparam int HALF = LINES / 2;

  logic [LINES-1:0] syncA, syncB, prevB;
  logic [LINES-1:0] evReg, maskReg, cfgLo, cfgHi;
  logic [LINES-1:0] hit;   // indexed by register bit position

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    localparam int B = LINES - 1 - n;
    logic riseEn, fallEn, isRise, isFall;
    assign isRise = syncB[n] & ~prevB[n];
    assign isFall = ~syncB[n] & prevB[n];
    if (TWO_BIT_CFG) begin : g_wide
      logic [1:0] code;
      if (n < HALF) begin : g_lo
        assign code = cfgLo[(HALF-1-n)*2 +: 2];
      end else begin : g_hi
        assign code = cfgHi[(HALF-1-(n-HALF))*2 +: 2];
      end
      assign riseEn = (code == 2'd0) || (code == 2'd1);
      assign fallEn = (code == 2'd0) || (code == 2'd2);
    end else begin : g_narrow
      assign riseEn = ~cfgLo[B];
      assign fallEn = 1'b1;
    end
    assign hit[B] = (riseEn & isRise) | (fallEn & isFall);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evReg   <= '0;
      maskReg <= '0;
      cfgLo   <= '0;
      cfgHi   <= '0;
    end else begin
      evReg <= (evReg & ~(strb.evClr ? wrData : '0)) | hit;
      if (strb.maskWr)  maskReg <= wrData;
      if (strb.cfgLoWr) cfgLo   <= wrData;
      if (strb.cfgHiWr) cfgHi   <= wrData;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_EVT:   rdData = evReg;
      RD_MASK:  rdData = maskReg;
      RD_CFGLO: rdData = cfgLo;
      RD_CFGHI: rdData = cfgHi;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = |(evReg & maskReg);

  // R4
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.evClr |=> (($past(evReg) & ~evReg) == '0));
  // R4
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evClr && hit == '0) |=> ((evReg & $past(wrData)) == '0));
  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit != '0) |=> ((evReg & $past(hit)) == $past(hit)));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.maskWr |=> $stable(maskReg));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgHiWr |=> $stable(cfgHi));
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int ADDR_W      = 5,
  parameter bit TWO_BIT_CFG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  pinIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [LINES-1:0]  regWrData,
  output logic [LINES-1:0]  regRdData,
  output logic              irqOut
);
  regStrobe_t strb;
  rdSel_e     rdSel;

  edge_irq_ctrl #(.ADDR_W(ADDR_W), .TWO_BIT_CFG(TWO_BIT_CFG)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb), .rdSel(rdSel)
  );

  edge_irq_datapath #(.LINES(LINES), .TWO_BIT_CFG(TWO_BIT_CFG)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strb(strb), .rdSel(rdSel),
    .wrData(regWrData), .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/edge_irq_unit_bench.sv
module edge_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pins = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        weN = 1'b0, weW = 1'b0;
  logic [31:0] rdN, rdW;
  logic        irqN, irqW;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  edge_irq_unit #(.TWO_BIT_CFG(1'b0)) u_edge_irq_unit (
    .clk(clk), .rstN(rstN), .pinIn(pins), .regAddr(addr), .regWrEn(weN),
    .regWrData(wdata), .regRdData(rdN), .irqOut(irqN));
  edge_irq_unit #(.TWO_BIT_CFG(1'b1)) u_edge_irq_unit_wide (
    .clk(clk), .rstN(rstN), .pinIn(pins), .regAddr(addr), .regWrEn(weW),
    .regWrData(wdata), .regRdData(rdW), .irqOut(irqW));

  typedef struct packed {
    logic       wide;
    logic [4:0] line;
    logic [1:0] code;
    logic       rise;
    logic       expSet;
  } vec_t;

  localparam vec_t VECS[16] = '{
    '{1'b0, 5'd0,  2'd0, 1'b1, 1'b1},
    '{1'b0, 5'd0,  2'd0, 1'b0, 1'b1},
    '{1'b0, 5'd5,  2'd1, 1'b1, 1'b0},
    '{1'b0, 5'd5,  2'd1, 1'b0, 1'b1},
    '{1'b0, 5'd31, 2'd1, 1'b0, 1'b1},
    '{1'b0, 5'd31, 2'd0, 1'b1, 1'b1},
    '{1'b1, 5'd0,  2'd2, 1'b0, 1'b1},
    '{1'b1, 5'd0,  2'd2, 1'b1, 1'b0},
    '{1'b1, 5'd3,  2'd1, 1'b1, 1'b1},
    '{1'b1, 5'd3,  2'd1, 1'b0, 1'b0},
    '{1'b1, 5'd15, 2'd0, 1'b1, 1'b1},
    '{1'b1, 5'd16, 2'd2, 1'b0, 1'b1},
    '{1'b1, 5'd20, 2'd1, 1'b1, 1'b1},
    '{1'b1, 5'd31, 2'd0, 1'b0, 1'b1},
    '{1'b1, 5'd31, 2'd3, 1'b1, 1'b0},
    '{1'b1, 5'd17, 2'd3, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input bit wide, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (wide) weW = 1'b1; else weN = 1'b1;
    @(negedge clk);
    weN = 1'b0; weW = 1'b0;
  endtask

  task automatic busRead(input bit wide, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = wide ? rdW : rdN;
  endtask

  task automatic waitCycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic clearAll();
    busWrite(1'b0, 5'h0C, 32'hFFFF_FFFF);
    busWrite(1'b1, 5'h0C, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    repeat (40000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    waitCycles(3);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      busRead(1'b1, 5'(8'h0C + 4 * i), r);
      check("R1 wide reg", r, 32'h0);
    end
    busRead(1'b0, 5'h0C, r); check("R1 event", r, 32'h0);
    busRead(1'b0, 5'h10, r); check("R1 mask", r, 32'h0);
    check("R1 irq", {31'h0, irqN | irqW}, 32'h0);

    // R2 decode
    busWrite(1'b0, 5'h18, 32'hA5A5_A5A5);
    busRead(1'b0, 5'h18, r); check("R2 narrow 0x18 ignored", r, 32'h0);
    busWrite(1'b1, 5'h18, 32'h1234_5678);
    busRead(1'b1, 5'h18, r); check("R2 wide 0x18", r, 32'h1234_5678);
    busWrite(1'b1, 5'h18, 32'h0);
    busWrite(1'b0, 5'h00, 32'hFFFF_FFFF);
    busRead(1'b0, 5'h00, r); check("R2 unmapped", r, 32'h0);
    busWrite(1'b0, 5'h14, 32'h0F0F_0000);
    busRead(1'b0, 5'h14, r); check("R2 cfg", r, 32'h0F0F_0000);

    // vector table: R3 bit order, R6 narrow, R7 placement, R8 codes
    foreach (VECS[i]) begin
      vec_t v;
      logic [4:0]  ca;
      logic [31:0] cd;
      v = VECS[i];
      if (v.wide) begin
        ca = (v.line < 16) ? 5'h14 : 5'h18;
        cd = 32'(v.code) << ((15 - (v.line % 16)) * 2);
        busWrite(1'b1, 5'h14, 32'h0);
        busWrite(1'b1, 5'h18, 32'h0);
        busWrite(1'b1, ca, cd);
      end else begin
        busWrite(1'b0, 5'h14, 32'(v.code[0]) << (31 - v.line));
      end
      pins[v.line] = ~v.rise;
      waitCycles(4);
      clearAll();
      pins[v.line] = v.rise;
      waitCycles(4);
      busRead(v.wide, 5'h0C, r);
      check($sformatf("R3/R6/R7/R8 vector %0d", i), r,
            v.expSet ? (32'h1 << (31 - v.line)) : 32'h0);
      pins = '0;
      waitCycles(4);
      clearAll();
    end
    busWrite(1'b0, 5'h14, 32'h0);
    busWrite(1'b1, 5'h14, 32'h0);

    // R10 latency and R5 interrupt
    busWrite(1'b0, 5'h10, 32'h0000_0002);   // line 30 enabled
    @(negedge clk); pins[30] = 1'b1;        // N0
    @(negedge clk);                         // N1 (after P1)
    @(negedge clk);                         // N2 (after P2)
    addr = 5'h0C; #1;
    check("R10 not yet set", rdN, 32'h0);
    check("R10 irq not yet", {31'h0, irqN}, 32'h0);
    @(negedge clk); #1;                     // after P3
    check("R10 set after third edge", rdN, 32'h0000_0002);
    check("R5 irq unmasked", {31'h0, irqN}, 32'h1);
    busWrite(1'b0, 5'h10, 32'h0);
    #1; check("R5 irq masked", {31'h0, irqN}, 32'h0);

    // R4 write 0 keeps, write 1 clears
    busWrite(1'b0, 5'h0C, 32'hFFFF_FFFD);
    busRead(1'b0, 5'h0C, r); check("R4 write 0 keeps", r, 32'h0000_0002);
    busWrite(1'b0, 5'h0C, 32'h0000_0002);
    busRead(1'b0, 5'h0C, r); check("R4 write 1 clears", r, 32'h0);

    // R5 masked event still latches
    @(negedge clk); pins[30] = 1'b0;
    waitCycles(4);
    busRead(1'b0, 5'h0C, r); check("R5 set while masked", r, 32'h0000_0002);
    check("R5 no irq while masked", {31'h0, irqN}, 32'h0);
    busWrite(1'b0, 5'h10, 32'h0000_0002);
    #1; check("R5 irq on unmask", {31'h0, irqN}, 32'h1);
    clearAll();
    #1; check("R5 irq drops on clear", {31'h0, irqN}, 32'h0);

    // R9 edge and clear in same cycle
    @(negedge clk); pins[30] = 1'b1;        // N0
    @(negedge clk);                         // N1
    @(negedge clk);                         // N2: clear strobe covers P3
    addr = 5'h0C; wdata = 32'hFFFF_FFFF; weN = 1'b1;
    @(negedge clk); weN = 1'b0; #1;
    check("R9 edge wins over clear", rdN, 32'h0000_0002);
    check("R9 irq", {31'h0, irqN}, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule